// File: doc/BRIEF.md
# GPIO and Control Register Bank

This block is a sixteen-line general-purpose I/O peripheral with a small bank of 16-bit control registers. A host reaches it over a plain synchronous register bus: address, write enable, read enable, write data and read data. Writes land on the clock edge where write enable is high. Read data is combinational from the stored state. Only the low six address bits are decoded, so the register map repeats every 64 bytes. Write data is cut to its low 16 bits before it is stored.

The pin logic keeps a direction mask and a level register. The output pins show only the level bits whose lines are set as outputs. The pins are refreshed only when software writes the direction or the level. External input lines can set or clear level bits on their own edges. Those changes stay invisible on the pins until the next such write. Around the pin logic sit six plain storage registers, a fixed status value and a power register that has one special write rule. An optional one-cycle error pulse flags any access to an offset that decodes to nothing.

Top module: `gpio_regbank`

## Requirements
- R1: After reset every offset reads 0, except offset 0x08, which reads 0x0002. `pin_out` is 0 and `err_o` is 0.
- R2: Offsets 0x00, 0x04, 0x10, 0x14, 0x18 and 0x1C are plain storage. Each stores the low 16 bits of a write and reads them back. Read data bits 31..16 are always 0.
- R3: A write to offset 0x0C stores the low 16 bits. When bit 7 of the written value is 1, bits 15 and 6 of the stored value are also set. Such a write of 0x0080 reads back as 0x80C0.
- R4: Offset 0x08 always reads 0x0002. Writes to it change nothing.
- R5: A write to offset 0x24 or 0x28 stores (write data AND direction) into the level register. Both offsets read the level register.
- R6: Offset 0x20 holds the direction mask. In the cycle after a write to 0x20, 0x24 or 0x28, `pin_out` equals the new (level AND direction). At any other time `pin_out` holds its value. A direction write leaves the level register as it was.
- R7: A rising edge on `pin_in[i]` sets level bit i, and a falling edge clears it, whatever the direction. `pin_out` does not change as a result. When a level write and a pin edge fall in the same cycle, the bus value wins.
- R8: Address bits above bit 5 are ignored. For example, 0x040 and 0x7C0 reach the register at offset 0x00.
- R9: An offset that names no register reads 0, and a write to it changes no register. Examples are 0x2C, 0x3C and 0x01.
- R10: With ERR_EN set, `err_o` is high for exactly the cycle after a read or write to an undecoded offset, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address; low 6 bits decoded |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable (used only for the error pulse) |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rdata | output | BUS_W (32) | Read data, combinational |
| pin_in | input | NPINS (16) | External level inputs, edge-sensed |
| pin_out | output | NPINS (16) | Output pins, level AND direction |
| err_o | output | 1 | One-cycle undecoded-access pulse |

## Verification
The hardest state to reach is the one where the level register and the pins disagree. An external edge changes a level bit, but the pins still show the old value. The stimulus first sets up a direction and a level, then toggles input lines, reads the level back over the bus, and confirms that `pin_out` has not moved. Only after a direction rewrite does the bench confirm that the change appears on the pins. A second awkward case is an input edge and a level write that fall in the very same cycle. The bench drives both at one clock edge so that the bus priority can be seen.

// File: rtl/gpio_regbank_pkg.sv
`timescale 1ns/1ps
package gpio_regbank_pkg;
  localparam int OFF_W = 6;

  localparam logic [OFF_W-1:0] OFF_MODE = 6'h00;
  localparam logic [OFF_W-1:0] OFF_CDIV = 6'h04;
  localparam logic [OFF_W-1:0] OFF_STAT = 6'h08;
  localparam logic [OFF_W-1:0] OFF_PWR  = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_CCTL = 6'h10;
  localparam logic [OFF_W-1:0] OFF_IREQ = 6'h14;
  localparam logic [OFF_W-1:0] OFF_IMSK = 6'h18;
  localparam logic [OFF_W-1:0] OFF_ISTS = 6'h1C;
  localparam logic [OFF_W-1:0] OFF_DIR  = 6'h20;
  localparam logic [OFF_W-1:0] OFF_LVLW = 6'h24;
  localparam logic [OFF_W-1:0] OFF_LVLR = 6'h28;

  // The first NPLAIN selects are plain storage, in array order
  typedef enum logic [3:0] {
    SEL_MODE, SEL_CDIV, SEL_CCTL, SEL_IREQ, SEL_IMSK, SEL_ISTS,
    SEL_STAT, SEL_PWR, SEL_DIR, SEL_LVL, SEL_NONE
  } sel_e;

  localparam int NPLAIN = 6;

  localparam logic [15:0] STAT_VALUE = 16'h0002;
  localparam int          PWR_TRIG   = 7;
  localparam logic [15:0] PWR_FORCE  = 16'h8040;
endpackage

// File: rtl/gpio_regbank_decode.sv
`timescale 1ns/1ps
module gpio_regbank_decode
  import gpio_regbank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel
);
  logic [OFF_W-1:0] off;
  logic             unused_hi;

  assign off       = addr[OFF_W-1:0];
  assign unused_hi = ^addr[ADDR_W-1:OFF_W];

  always_comb begin
    unique case (off)
      OFF_MODE: sel = SEL_MODE;
      OFF_CDIV: sel = SEL_CDIV;
      OFF_STAT: sel = SEL_STAT;
      OFF_PWR:  sel = SEL_PWR;
      OFF_CCTL: sel = SEL_CCTL;
      OFF_IREQ: sel = SEL_IREQ;
      OFF_IMSK: sel = SEL_IMSK;
      OFF_ISTS: sel = SEL_ISTS;
      OFF_DIR:  sel = SEL_DIR;
      OFF_LVLW: sel = SEL_LVL;
      OFF_LVLR: sel = SEL_LVL;
      default:  sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/gpio_regbank_regs.sv
`timescale 1ns/1ps
module gpio_regbank_regs
  import gpio_regbank_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NPLAIN-1:0]                 plain_we,
  input  logic                              pwr_we,
  input  logic [REG_W-1:0]                  wdata,
  output logic [NPLAIN-1:0][REG_W-1:0]      plain_q,
  output logic [REG_W-1:0]                  power_q
);
  logic [NPLAIN-1:0][REG_W-1:0] plain_d;
  logic [REG_W-1:0]             power_d;
  logic [REG_W-1:0]             force_mask;

  for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
    always_comb begin
      plain_d[g] = plain_q[g];
      if (plain_we[g]) plain_d[g] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) plain_q[g] <= '0;
      else        plain_q[g] <= plain_d[g];
    end
  end

  always_comb begin
    force_mask = '0;
    if (wdata[PWR_TRIG]) force_mask = REG_W'(PWR_FORCE);
    power_d = power_q;
    if (pwr_we) power_d = wdata | force_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) power_q <= '0;
    else        power_q <= power_d;
  end
endmodule

// File: rtl/gpio_regbank_pins.sv
`timescale 1ns/1ps
module gpio_regbank_pins #(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_we,
  input  logic             lvl_we,
  input  logic [NPINS-1:0] wdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] lvl_q,
  output logic [NPINS-1:0] pin_out
);
  logic [NPINS-1:0] dir_d, lvl_d, out_d, out_q;
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] pin_edge;

  assign pin_edge = pin_in ^ prev_q;

  always_comb begin
    dir_d = dir_q;
    if (dir_we) dir_d = wdata;
  end

  // Bus write has priority over an input edge in the same cycle
  for (genvar i = 0; i < NPINS; i++) begin : g_lvl
    always_comb begin
      lvl_d[i] = lvl_q[i];
      if (lvl_we)           lvl_d[i] = wdata[i] & dir_q[i];
      else if (pin_edge[i]) lvl_d[i] = pin_in[i];
    end
  end

  always_comb begin
    out_d = out_q;
    if (dir_we || lvl_we) out_d = lvl_d & dir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
      out_q  <= '0;
    end else begin
      dir_q  <= dir_d;
      lvl_q  <= lvl_d;
      prev_q <= pin_in;
      out_q  <= out_d;
    end
  end

  assign pin_out = out_q;
endmodule

// File: rtl/gpio_regbank.sv
`timescale 1ns/1ps
module gpio_regbank
  import gpio_regbank_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 32,
  parameter int NPINS  = 16,
  parameter bit ERR_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic              err_o
);
  localparam int REG_W = 16;

  // Asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  sel_e                          sel;
  logic [REG_W-1:0]              wdata16;
  logic                          unused_wdata;
  logic [NPLAIN-1:0]             plain_we;
  logic [NPLAIN-1:0][REG_W-1:0]  plain_q;
  logic [REG_W-1:0]              power_q;
  logic [NPINS-1:0]              dir_q, lvl_q;
  logic                          dir_we, lvl_we, pwr_we;

  assign wdata16      = bus_wdata[REG_W-1:0];
  assign unused_wdata = ^bus_wdata[BUS_W-1:REG_W];

  gpio_regbank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  for (genvar g = 0; g < NPLAIN; g++) begin : g_we
    assign plain_we[g] = bus_we && (sel == sel_e'(g));
  end
  assign pwr_we = bus_we && (sel == SEL_PWR);
  assign dir_we = bus_we && (sel == SEL_DIR);
  assign lvl_we = bus_we && (sel == SEL_LVL);

  gpio_regbank_regs #(.REG_W(REG_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .plain_we (plain_we),
    .pwr_we   (pwr_we),
    .wdata    (wdata16),
    .plain_q  (plain_q),
    .power_q  (power_q)
  );

  gpio_regbank_pins #(.NPINS(NPINS)) u_pins (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .dir_we  (dir_we),
    .lvl_we  (lvl_we),
    .wdata   (wdata16[NPINS-1:0]),
    .pin_in  (pin_in),
    .dir_q   (dir_q),
    .lvl_q   (lvl_q),
    .pin_out (pin_out)
  );

  // Read mux
  logic [REG_W-1:0] rd_field;

  always_comb begin
    rd_field = '0;
    for (int g = 0; g < NPLAIN; g++) begin
      if (sel == sel_e'(g)) rd_field = plain_q[g];
    end
    case (sel)
      SEL_STAT: rd_field = STAT_VALUE;
      SEL_PWR:  rd_field = power_q;
      SEL_DIR:  rd_field[NPINS-1:0] = dir_q;
      SEL_LVL:  rd_field[NPINS-1:0] = lvl_q;
      default:  ;
    endcase
    bus_rdata = '0;
    bus_rdata[REG_W-1:0] = rd_field;
  end

  // Undecoded-access pulse
  if (ERR_EN) begin : g_err
    logic err_d, err_q;
    assign err_d = (bus_we || bus_re) && (sel == SEL_NONE);
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) err_q <= 1'b0;
      else             err_q <= err_d;
    end
    assign err_o = err_q;
  end else begin : g_noerr
    assign err_o = 1'b0;
  end
endmodule

// File: rtl/gpio_regbank_chk.sv
`timescale 1ns/1ps
module gpio_regbank_chk #(
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 32,
  parameter int NPINS  = 16,
  parameter bit ERR_EN = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              we,
  input logic              re,
  input logic [BUS_W-1:0]  wdata,
  input logic [BUS_W-1:0]  rdata,
  input logic [NPINS-1:0]  pin_out,
  input logic              err_o,
  input logic [NPINS-1:0]  dir_i,
  input logic [NPINS-1:0]  lvl_i,
  input logic [15:0]       power_i
);
  logic [5:0] off;
  logic       known, pin_wr, lvl_wr;

  assign off    = addr[5:0];
  assign known  = (off[1:0] == 2'b00) && (off <= 6'h28);
  assign lvl_wr = we && (off == 6'h24 || off == 6'h28);
  assign pin_wr = lvl_wr || (we && off == 6'h20);

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_wr |=> $stable(pin_out));

  assert_lvl_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_wr |=> ((lvl_i & ~$past(dir_i)) == '0));

  assert_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (off == 6'h08) |-> (rdata == 32'h2));

  assert_power_force_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && off == 6'h0C && wdata[7]) |=> (power_i[15] && power_i[6]));

  assert_undec_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !known |-> (rdata == '0));

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[BUS_W-1:16] == '0);

  if (ERR_EN) begin : g_err_chk
    assert_err_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((we || re) && !known) |=> err_o);
    assert_err_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !((we || re) && !known) |=> !err_o);
  end
endmodule

bind gpio_regbank gpio_regbank_chk #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .NPINS(NPINS), .ERR_EN(ERR_EN)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .addr    (bus_addr),
  .we      (bus_we),
  .re      (bus_re),
  .wdata   (bus_wdata),
  .rdata   (bus_rdata),
  .pin_out (pin_out),
  .err_o   (err_o),
  .dir_i   (dir_q),
  .lvl_i   (lvl_q),
  .power_i (power_q)
);

// File: tb/gpio_regbank_test.sv
`timescale 1ns/1ps
module gpio_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_we, bus_re;
  logic [31:0] bus_wdata, bus_rdata;
  logic [15:0] pin_in, pin_out;
  logic        err_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gpio_regbank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .err_o(err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 pin_out", {16'h0, pin_out}, 32'h0);
    chk("R1 err_o", {31'h0, err_o}, 32'h0);
    for (int a = 0; a <= 'h28; a += 4) begin
      rd(12'(a), d);
      chk($sformatf("R1 reset read 0x%0h", a), d, (a == 8) ? 32'h2 : 32'h0);
    end
  endtask

  task automatic t_plain;
    logic [31:0] d;
    logic [11:0] offs [6] = '{12'h00, 12'h04, 12'h10, 12'h14, 12'h18, 12'h1C};
    for (int k = 0; k < 6; k++) wr(offs[k], 32'hABCD_0000 | (32'h1111 * (k + 1)));
    for (int k = 0; k < 6; k++) begin
      rd(offs[k], d);
      chk($sformatf("R2 plain 0x%0h", offs[k]), d, 32'h1111 * (k + 1));
    end
  endtask

  task automatic t_power;
    logic [31:0] d;
    wr(12'h0C, 32'h0080); rd(12'h0C, d); chk("R3 power 0x80", d, 32'h80C0);
    wr(12'h0C, 32'h0001); rd(12'h0C, d); chk("R3 power 0x01", d, 32'h0001);
    wr(12'h0C, 32'hFFFF_1234); rd(12'h0C, d); chk("R3 power 0x1234", d, 32'h1234);
    wr(12'h0C, 32'h00FF); rd(12'h0C, d); chk("R3 power 0xFF", d, 32'h80FF);
  endtask

  task automatic t_status;
    logic [31:0] d;
    wr(12'h08, 32'hFFFF); rd(12'h08, d); chk("R4 status after write", d, 32'h2);
  endtask

  task automatic t_gpio;
    logic [31:0] d;
    wr(12'h20, 32'h00FF);
    chk("R6 out after dir, level 0", {16'h0, pin_out}, 32'h0);
    wr(12'h24, 32'hFFFF);
    rd(12'h24, d); chk("R5 level via 0x24", d, 32'h00FF);
    rd(12'h28, d); chk("R5 level via 0x28", d, 32'h00FF);
    chk("R6 out after level write", {16'h0, pin_out}, 32'h00FF);
    wr(12'h20, 32'h0F0F);
    chk("R6 out after dir change", {16'h0, pin_out}, 32'h000F);
    rd(12'h24, d); chk("R6 level kept on dir write", d, 32'h00FF);
    wr(12'h28, 32'hFFFF);
    rd(12'h24, d); chk("R5 write via 0x28", d, 32'h0F0F);
    chk("R6 out after 0x28 write", {16'h0, pin_out}, 32'h0F0F);
  endtask

  task automatic t_pin_in;
    logic [31:0] d;
    @(negedge clk); pin_in = 16'h00F0;
    rd(12'h24, d); chk("R7 rising input sets", d, 32'h0FFF);
    chk("R7 out unchanged by input", {16'h0, pin_out}, 32'h0F0F);
    @(negedge clk); pin_in = 16'h0001;
    @(negedge clk); pin_in = 16'h0000;
    rd(12'h24, d); chk("R7 falling input clears", d, 32'h0F0E);
    chk("R7 out still stale", {16'h0, pin_out}, 32'h0F0F);
    wr(12'h20, 32'h0F0F);
    chk("R7 out refreshed by dir write", {16'h0, pin_out}, 32'h0F0E);
    // same-cycle input edge and level write: bus wins
    @(negedge clk);
    bus_addr = 12'h24; bus_wdata = 32'h0; bus_we = 1'b1; pin_in = 16'h1000;
    @(negedge clk); bus_we = 1'b0;
    rd(12'h24, d); chk("R7 bus wins over input edge", d, 32'h0);
    @(negedge clk); pin_in = 16'h0000;
    rd(12'h24, d); chk("R7 level after input release", d, 32'h0);
  endtask

  task automatic t_alias;
    logic [31:0] d;
    wr(12'h040, 32'h5A5A);
    rd(12'h000, d); chk("R8 alias write 0x040", d, 32'h5A5A);
    rd(12'h7C0, d); chk("R8 alias read 0x7C0", d, 32'h5A5A);
  endtask

  task automatic t_undec;
    logic [31:0] d;
    wr(12'h20, 32'hFFFF); wr(12'h24, 32'h1234);
    wr(12'h2C, 32'hFFFF);
    chk("R10 err after undecoded write", {31'h0, err_o}, 32'h1);
    @(negedge clk);
    chk("R10 err drops", {31'h0, err_o}, 32'h0);
    wr(12'h001, 32'hFFFF);
    rd(12'h2C, d); chk("R9 read 0x2C", d, 32'h0);
    chk("R10 err after undecoded read", {31'h0, err_o}, 32'h1);
    rd(12'h03C, d); chk("R9 read 0x3C", d, 32'h0);
    rd(12'h001, d); chk("R9 read 0x01", d, 32'h0);
    rd(12'h000, d); chk("R9 mode untouched", d, 32'h5A5A);
    chk("R10 err low after decoded read", {31'h0, err_o}, 32'h0);
    rd(12'h024, d); chk("R9 level untouched", d, 32'h1234);
    chk("R9 pins untouched", {16'h0, pin_out}, 32'h1234);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_re = 1'b0;
    bus_wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_plain();
    t_power();
    t_status();
    t_gpio();
    t_pin_in();
    t_alias();
    t_undec();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule